// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block is the receive side of a byte-oriented serial port. A deserializer delivers whole bytes on a push port. Reads of the receive data register pop them again. With the FIFO mode switched on, up to sixteen bytes are held in arrival order. With the mode switched off, a single holding register takes their place. The block also owns the control register that switches the mode, flushes the queues and picks the trigger level. A pulse output lets a separate transmit queue be flushed from that same register.

A character-timeout counter measures four character times, where one character time is given in clock ticks on an input. It raises a pending flag when bytes sit in the queue and neither a push nor a pop has come for that long. The status outputs give the fill count, data-ready, overrun, break, a trigger-reached indication and the timeout flag. An interrupt controller and a line-status register can build on these outputs.

Top module: `rx_fifo_unit`

## Requirements
- R1: After reset, the fill count, data-ready, overrun, break, timeout-pending, trigger-reached and transmit-flush outputs are all 0, and the control value reads 0x00. This means FIFO mode is off.
- R2: In FIFO mode, bytes are popped in the order they were pushed, and the fill count follows every push and pop.
- R3: A push into a full 16-entry FIFO is dropped and sets overrun, and the stored bytes are kept. A push and a pop in the same cycle on a full FIFO are both accepted, with no overrun.
- R4: Control bits [7:6] choose the trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In FIFO mode, trigger-reached is high while the count is at or above that level. With FIFO mode off, trigger-reached follows data-ready.
- R5: Only control bits 7, 6, 3 and 0 are kept, and bit 0 is the FIFO enable. A control write equal to the current value changes nothing.
- R6: A control write with bit 1 set empties the receive FIFO and clears data-ready and timeout-pending, and it stops the timer. A write with bit 2 set gives a one-cycle transmit-flush pulse in the cycle after the write. A write equal to the current value does neither.
- R7: A control write that changes bit 0 performs both flushes, whatever the written bits 1 and 2 are.
- R8: In FIFO mode, every push, and every pop that leaves data behind, restarts a deadline of 4×char_ticks cycles. If that deadline runs out while the FIFO is not empty, timeout-pending rises exactly 4×char_ticks cycles after the restarting edge. Any pop clears it.
- R9: A pop that leaves no data clears data-ready and break. A push with the break mark sets break. A status read clears overrun and break.
- R10: With FIFO mode off, a byte arriving while data-ready is set, with no pop in that cycle, sets overrun and replaces the held byte.
- R11: A pop from an empty FIFO returns 0x00 and leaves the count at 0.
- R12: A receive flush in the same cycle as a push discards that push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_ticks | input | TICK_W | One character time in clock ticks |
| push_vld | input | 1 | Byte from the deserializer |
| push_data | input | DW | Received byte |
| push_brk | input | 1 | The pushed byte carries a break mark |
| pop_req | input | 1 | Read of the receive data register |
| pop_data | output | DW | Byte returned by the read (combinational) |
| lsr_rd | input | 1 | Status read; clears overrun and break |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_val | output | 8 | Retained control value |
| txq_flush | output | 1 | One-cycle flush pulse for the transmit queue |
| lvl_count | output | CW | FIFO fill count |
| trig_hit | output | 1 | Trigger level reached |
| data_rdy | output | 1 | Received data available |
| ovr_flag | output | 1 | Overrun seen |
| brk_flag | output | 1 | Break seen |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
Two pairs of functions can meet in the same cycle. A push can meet a pop while the FIFO is full. A push can meet a receive flush from a control write. The bench fills the FIFO to sixteen and then drives push and pop together. It checks that the oldest byte comes out, the count stays at sixteen, overrun stays low, and the new byte appears last in the drain order. It also drives a flushing control write and a push on the same edge, and checks that the count and data-ready are 0 afterwards. The flush wins over the push.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

   // control register bit positions (software-visible, so fixed)
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_RXCL_BIT = 1;
   localparam int CTL_TXCL_BIT = 2;
   localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;

   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'b00,
      TRIG_SEL_B = 2'b01,
      TRIG_SEL_C = 2'b10,
      TRIG_SEL_D = 2'b11
   } trig_sel_e;

endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_en) wp <= wp_nx;
         if (rd_en) rp <= rp_nx;
         case ({wr_en, rd_en})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign count   = cnt;
   assign rd_data = empty ? '0 : mem[rp];

   // R3: the caller never writes into a full array without a read
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en) |-> !full);
   // R11: the caller never reads an empty array
   p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
   // R2: a lone write raises the count by one
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && wr_en && !rd_en) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rx_fifo_ctlreg.sv
module rx_fifo_ctlreg
   import rx_fifo_pkg::*;
#(
   parameter int CW     = 5,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [7:0]    wdata,
   output logic [7:0]    ctl_q,
   output logic          fifo_on,
   output logic          rx_flush,
   output logic          tx_flush_q,
   output logic [CW-1:0] trig_lvl
);

   logic chg, tog, tx_now;

   assign chg      = wr && (wdata != ctl_q);
   assign tog      = chg && (wdata[CTL_EN_BIT] != ctl_q[CTL_EN_BIT]);
   assign rx_flush = chg && (wdata[CTL_RXCL_BIT] || tog);
   assign tx_now   = chg && (wdata[CTL_TXCL_BIT] || tog);
   assign fifo_on  = ctl_q[CTL_EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= 8'h00;
         tx_flush_q <= 1'b0;
      end else begin
         tx_flush_q <= tx_now;
         if (chg) ctl_q <= wdata & CTL_KEEP_MASK;
      end
   end

   always_comb begin
      case (trig_sel_e'(ctl_q[7:6]))
         TRIG_SEL_A: trig_lvl = CW'(TRIG_A);
         TRIG_SEL_B: trig_lvl = CW'(TRIG_B);
         TRIG_SEL_C: trig_lvl = CW'(TRIG_C);
         default:    trig_lvl = CW'(TRIG_D);
      endcase
   end

   // R5: rewriting the current value leaves state and pulses alone
   p_same_write_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (wdata == ctl_q)) |=> ($stable(ctl_q) && !tx_flush_q));
   // R7: an enable change always yields a transmit flush pulse
   p_toggle_txflush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (wdata[CTL_EN_BIT] != ctl_q[CTL_EN_BIT])) |=> tx_flush_q);

endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo #(
   parameter int TICK_W = 16,
   localparam int SW    = TICK_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] char_ticks,
   input  logic              arm,
   input  logic              stop,
   output logic              expire
);

   logic [SW-1:0] cnt;
   logic          run;

   assign expire = run && (cnt <= SW'(1)) && !arm && !stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (stop) begin
         run <= 1'b0;
      end else if (arm) begin
         cnt <= {char_ticks, 2'b00};
         run <= 1'b1;
      end else if (run) begin
         if (cnt <= SW'(1)) run <= 1'b0;
         else               cnt <= cnt - 1'b1;
      end
   end

   // R6: a stop always leaves the timer idle
   p_stop_idles_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !expire);

endmodule

// File: rtl/rx_fifo_unit.sv
module rx_fifo_unit #(
   parameter int DEPTH  = 16,
   parameter int DW     = 8,
   parameter int TICK_W = 16,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TICK_W-1:0] char_ticks,
   input  logic              push_vld,
   input  logic [DW-1:0]     push_data,
   input  logic              push_brk,
   input  logic              pop_req,
   output logic [DW-1:0]     pop_data,
   input  logic              lsr_rd,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_val,
   output logic              txq_flush,
   output logic [CW-1:0]     lvl_count,
   output logic              trig_hit,
   output logic              data_rdy,
   output logic              ovr_flag,
   output logic              brk_flag,
   output logic              tmo_pend
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_fifo_unit: DEPTH must be at least 2");
      end
      if (TRIG_A < 1 || TRIG_D > DEPTH || TRIG_B > DEPTH || TRIG_C > DEPTH) begin : g_bad_trig
         $error("rx_fifo_unit: trigger levels must lie in 1..DEPTH");
      end
      if (TICK_W < 1) begin : g_bad_tick
         $error("rx_fifo_unit: TICK_W must be positive");
      end
   endgenerate

   logic          fifo_on, rx_flush;
   logic [CW-1:0] trig_lvl, cnt;
   logic          full, empty;
   logic [DW-1:0] st_rd_data;
   logic          push_ok, pop_ok, st_rd, st_wr, fifo_ovf, hold_ovf, emptying;
   logic          tmr_arm, tmr_expire;
   logic [DW-1:0] hold_q;

   rx_fifo_ctlreg #(
      .CW(CW), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ctl_wr),
      .wdata     (ctl_wdata),
      .ctl_q     (ctl_val),
      .fifo_on   (fifo_on),
      .rx_flush  (rx_flush),
      .tx_flush_q(txq_flush),
      .trig_lvl  (trig_lvl)
   );

   // a flush in the same cycle beats any push or pop
   assign push_ok  = push_vld && !rx_flush;
   assign pop_ok   = pop_req && !rx_flush;
   assign st_rd    = fifo_on && pop_ok && !empty;
   assign st_wr    = fifo_on && push_ok && (!full || st_rd);
   assign fifo_ovf = fifo_on && push_ok && full && !st_rd;
   assign hold_ovf = !fifo_on && push_ok && data_rdy && !pop_ok;
   assign emptying = pop_ok && !push_ok && (!fifo_on || (cnt <= CW'(1)));

   rx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (rx_flush),
      .wr_en  (st_wr),
      .wr_data(push_data),
      .rd_en  (st_rd),
      .rd_data(st_rd_data),
      .count  (cnt),
      .full   (full),
      .empty  (empty)
   );

   assign tmr_arm = fifo_on && (push_ok || (pop_ok && (cnt > CW'(1))));

   rx_fifo_tmo #(.TICK_W(TICK_W)) u_tmo (
      .clk       (clk),
      .rst_n     (rst_n),
      .char_ticks(char_ticks),
      .arm       (tmr_arm),
      .stop      (rx_flush),
      .expire    (tmr_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         data_rdy <= 1'b0;
         ovr_flag <= 1'b0;
         brk_flag <= 1'b0;
         tmo_pend <= 1'b0;
      end else begin
         if (!fifo_on && push_ok) hold_q <= push_data;

         if (rx_flush)      data_rdy <= 1'b0;
         else if (push_ok)  data_rdy <= 1'b1;
         else if (emptying) data_rdy <= 1'b0;

         if (fifo_ovf || hold_ovf) ovr_flag <= 1'b1;
         else if (lsr_rd)          ovr_flag <= 1'b0;

         if (push_ok && push_brk)    brk_flag <= 1'b1;
         else if (lsr_rd || emptying) brk_flag <= 1'b0;

         if (rx_flush || pop_ok)             tmo_pend <= 1'b0;
         else if (tmr_expire && !empty)      tmo_pend <= 1'b1;
      end
   end

   assign pop_data  = fifo_on ? st_rd_data : hold_q;
   assign lvl_count = cnt;
   assign trig_hit  = fifo_on ? (cnt >= trig_lvl) : data_rdy;

   // R6: a receive flush leaves an empty queue and no pending timeout
   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> ((lvl_count == '0) && !tmo_pend && !data_rdy));
   // R8: timeout pending only ever rises with data in the queue
   p_tmo_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_pend) |-> (lvl_count != '0));
   // R10: a byte onto an occupied holding register raises overrun
   p_hold_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_on && push_vld && data_rdy && !pop_req && !rx_flush) |=> ovr_flag);
   // R3: a push into a full queue without a pop keeps the count and flags overrun
   p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && push_vld && full && !pop_req && !rx_flush)
         |=> (ovr_flag && (lvl_count == CW'(DEPTH))));

endmodule

// File: tb/tb_rx_fifo_unit.sv
`timescale 1ns/1ps
module tb_rx_fifo_unit;

   localparam int DEPTH = 16;
   localparam int TK    = 3;
   localparam int SPAN  = 4 * TK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] char_ticks = 16'(TK);
   logic        push_vld = 1'b0;
   logic [7:0]  push_data = 8'h00;
   logic        push_brk = 1'b0;
   logic        pop_req = 1'b0;
   logic [7:0]  pop_data;
   logic        lsr_rd = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = 8'h00;
   logic [7:0]  ctl_val;
   logic        txq_flush;
   logic [4:0]  lvl_count;
   logic        trig_hit, data_rdy, ovr_flag, brk_flag, tmo_pend;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] mdl[$];

   always #2.5 clk = ~clk;

   rx_fifo_unit dut (
      .clk(clk), .rst_n(rst_n), .char_ticks(char_ticks),
      .push_vld(push_vld), .push_data(push_data), .push_brk(push_brk),
      .pop_req(pop_req), .pop_data(pop_data), .lsr_rd(lsr_rd),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_val(ctl_val),
      .txq_flush(txq_flush), .lvl_count(lvl_count), .trig_hit(trig_hit),
      .data_rdy(data_rdy), .ovr_flag(ovr_flag), .brk_flag(brk_flag),
      .tmo_pend(tmo_pend)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input int t);
      return 8'((k * 37 + t * 11 + 5) & 255);
   endfunction

   task automatic do_push(input logic [7:0] b, input logic brk);
      push_vld = 1'b1; push_data = b; push_brk = brk;
      @(negedge clk);
      push_vld = 1'b0; push_brk = 1'b0;
   endtask

   task automatic do_pop(input string req, input logic [7:0] exp);
      pop_req = 1'b1;
      #1 check(req, pop_data, exp);
      @(negedge clk);
      pop_req = 1'b0;
   endtask

   task automatic do_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic do_lsr();
      lsr_rd = 1'b1;
      @(negedge clk);
      lsr_rd = 1'b0;
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 count", lvl_count, 0);
      check("R1 data_rdy", data_rdy, 0);
      check("R1 ovr", ovr_flag, 0);
      check("R1 brk", brk_flag, 0);
      check("R1 tmo", tmo_pend, 0);
      check("R1 trig", trig_hit, 0);
      check("R1 ctl", ctl_val, 8'h00);
      check("R1 txflush", txq_flush, 0);

      // R10 holding register mode
      do_push(8'h5A, 1'b0);
      check("R10 rdy", data_rdy, 1);
      check("R10 count", lvl_count, 0);
      check("R4 trig follows rdy", trig_hit, 1);
      check("R10 no ovr yet", ovr_flag, 0);
      do_push(8'hA5, 1'b0);
      check("R10 ovr", ovr_flag, 1);
      do_pop("R10 newest byte", 8'hA5);
      check("R9 rdy cleared", data_rdy, 0);
      do_lsr();
      check("R9 ovr cleared by status read", ovr_flag, 0);
      do_push(8'h11, 1'b1);
      check("R9 brk set", brk_flag, 1);
      do_pop("R10 byte", 8'h11);
      check("R9 brk cleared by emptying pop", brk_flag, 0);

      // R2 R3 R4 R11 sweep over all trigger selections
      for (int s = 0; s < 4; s++) begin
         automatic int lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
         automatic logic [7:0] cv = 8'((s << 6) | 1);
         do_ctl(cv);
         check("R5 retained ctl", ctl_val, cv);
         check("R2 empty after enable", lvl_count, 0);
         mdl.delete();
         for (int i = 1; i <= DEPTH; i++) begin
            do_push(pat(i, s), 1'b0);
            mdl.push_back(pat(i, s));
            check("R2 count", lvl_count, i);
            check("R4 trigger", trig_hit, (i >= lvl) ? 1 : 0);
         end
         do_ctl(cv);
         check("R5 same write keeps count", lvl_count, DEPTH);
         check("R5 same write no pulse", txq_flush, 0);
         do_push(8'hEE, 1'b0);
         check("R3 overrun", ovr_flag, 1);
         check("R3 count held", lvl_count, DEPTH);
         do_lsr();
         if (s == 3) begin
            // R3 simultaneous push and pop on a full FIFO
            push_vld = 1'b1; push_data = 8'hC3;
            pop_req = 1'b1;
            #1 check("R3 same-cycle pop data", pop_data, mdl[0]);
            @(negedge clk);
            push_vld = 1'b0; pop_req = 1'b0;
            void'(mdl.pop_front());
            mdl.push_back(8'hC3);
            check("R3 same-cycle count", lvl_count, DEPTH);
            check("R3 same-cycle no ovr", ovr_flag, 0);
         end
         for (int i = DEPTH; i >= 1; i--) begin
            automatic logic [7:0] e = mdl.pop_front();
            do_pop("R2 order", e);
            check("R2 count on pop", lvl_count, i - 1);
         end
         check("R9 rdy after drain", data_rdy, 0);
         do_pop("R11 empty pop", 8'h00);
         check("R11 count stays", lvl_count, 0);
      end

      // R8 timeout (ctl is 0xC1)
      do_push(8'h21, 1'b0);
      for (int k = 1; k < SPAN; k++) begin
         @(negedge clk);
         check("R8 not yet", tmo_pend, 0);
      end
      @(negedge clk);
      check("R8 expiry", tmo_pend, 1);
      do_push(8'h22, 1'b0);
      do_pop("R8 data", 8'h21);
      check("R8 pop clears", tmo_pend, 0);
      for (int k = 1; k < SPAN; k++) begin
         @(negedge clk);
         check("R8 rearmed not yet", tmo_pend, 0);
      end
      @(negedge clk);
      check("R8 rearmed expiry", tmo_pend, 1);
      do_pop("R8 last", 8'h22);
      check("R8 emptying pop clears", tmo_pend, 0);
      repeat (SPAN + 2) @(negedge clk);
      check("R8 empty no pend", tmo_pend, 0);

      // R6 receive flush
      do_push(8'h31, 1'b0);
      do_push(8'h32, 1'b0);
      repeat (SPAN) @(negedge clk);
      check("R8 pend before flush", tmo_pend, 1);
      do_ctl(8'hC3);
      check("R6 count", lvl_count, 0);
      check("R6 rdy", data_rdy, 0);
      check("R6 tmo", tmo_pend, 0);
      check("R6 ctl kept", ctl_val, 8'hC1);
      check("R6 no tx pulse", txq_flush, 0);
      do_push(8'h33, 1'b0);
      do_ctl(8'hC5);
      check("R6 tx pulse", txq_flush, 1);
      check("R6 rx kept", lvl_count, 1);
      @(negedge clk);
      check("R6 tx pulse ends", txq_flush, 0);

      // R7 enable toggles
      do_ctl(8'hC0);
      check("R7 count", lvl_count, 0);
      check("R7 tx pulse", txq_flush, 1);
      check("R7 rdy", data_rdy, 0);
      do_push(8'h44, 1'b0);
      check("R10 rdy disabled", data_rdy, 1);
      do_ctl(8'h01);
      check("R7 rdy on enable", data_rdy, 0);
      check("R7 tx pulse on enable", txq_flush, 1);
      check("R7 ctl", ctl_val, 8'h01);

      // R12 flush beats push
      do_push(8'h55, 1'b0);
      push_vld = 1'b1; push_data = 8'h66;
      ctl_wr = 1'b1; ctl_wdata = 8'h03;
      @(negedge clk);
      push_vld = 1'b0; ctl_wr = 1'b0;
      check("R12 count", lvl_count, 0);
      check("R12 rdy", data_rdy, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule